// File: doc/BRIEF.md
# Event Counter with Assignable Prescaler

This block is an 8-bit event counter paired with one 8-bit binary prescaler. Software sets up the block through a 6-bit mode register. The counter counts one of two sources. The first is an instruction-cycle enable that comes from the core. The second is transitions on an external pin, after that pin has passed through a two-flop synchroniser and an edge detector. The mode register also chooses which edge of the pin counts.

The prescaler has exactly one user at a time. When it is given to the counter, it divides the counter's source events before they reach the counter. When it is given to the watchdog path, it divides the incoming watchdog tick and sends the result out for the watchdog's timeout logic. In that case the counter counts every source event directly. The divide code is the same 3-bit value in both cases, but the ratio it gives differs by one power of two:
- code `k` divides by 2^(k+1) for the counter;
- code `k` divides by 2^k for the watchdog.

The core can read the counter at any time and can load it with a new value. The counter wraps from FFh to 00h and raises a one-cycle overflow pulse when it does. Every pin is a plain register-style control or status signal. No streaming data passes through the block, so no port has a valid/ready handshake and none can apply back-pressure.

Top module: `rtc_timer`

## Requirements
- R1: While `rst_n` is low and after its release, `mode_value` reads 6'b111111, `cnt_value` reads 00h and `ovf_pulse` is 0.
- R2: Mode bit 5 picks the counting source. At 0 each cycle with `cyc_en` high is one event. At 1 each selected edge of `ext_pin` is one event, and `cyc_en` is ignored.
- R3: Mode bit 4 picks the pin edge: 0 counts rising edges and 1 counts falling edges. With the prescaler on the watchdog, a pin change that is sampled at clock edge j shows up in `cnt_value` after clock edge j+2.
- R4: With mode bit 3 at 0, the prescaler serves the counter. The counter then advances once per 2^(k+1) events, where k is mode bits 2..0, so k=0 gives 1:2 and k=7 gives 1:256.
- R5: With mode bit 3 at 1, the prescaler serves the watchdog. `wdt_tick_out` then pulses once per 2^k cycles of `wdt_tick_in` high, in the same cycle as the tick that completes the count, so k=0 gives 1:1 and k=7 gives 1:128.
- R6: With mode bit 3 at 1, the counter advances on every source event. With mode bit 3 at 0, `wdt_tick_out` equals `wdt_tick_in` in the same cycle.
- R7: A cycle with `cnt_wr_en` high loads `cnt_wr_data`, and the new value is seen after that clock edge. The load wins over an increment that falls in the same cycle, and no overflow is raised in that cycle.
- R8: A counter write clears the prescaler's count only while mode bit 3 is 0. While the prescaler serves the watchdog, its count is kept.
- R9: An increment from FFh gives 00h, and `ovf_pulse` is high for exactly the one cycle in which `cnt_value` first reads 00h.
- R10: A cycle with `mode_wr_en` high loads `mode_wr_data`, and `mode_value` shows it after that clock edge. Events in the write cycle still obey the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_en | input | 1 | Instruction-cycle enable, an event source |
| ext_pin | input | 1 | Asynchronous external count pin |
| cnt_wr_en | input | 1 | Counter load strobe |
| cnt_wr_data | input | 8 | Value to load into the counter |
| mode_wr_en | input | 1 | Mode register load strobe |
| mode_wr_data | input | 6 | New mode: [5] pin source, [4] falling edge, [3] to watchdog, [2:0] divide code |
| wdt_tick_in | input | 1 | Raw watchdog tick |
| cnt_value | output | 8 | Current counter value |
| mode_value | output | 6 | Current mode register |
| wdt_tick_out | output | 1 | Tick passed on to the watchdog path |
| ovf_pulse | output | 1 | One-cycle counter wrap pulse |

## Verification
A counter load can land in the same cycle as an increment. When it does, it can also hide a wrap from FFh and, with the prescaler serving the counter, reset the prescaler count. The bench provokes this clash directly: it loads the counter while `cyc_en` is high, and it loads again a few events into a division period. The random phase then repeats the clash many times at random points. Each result is judged against a cycle-exact reference model that applies the load-wins rule, which means no increment, no overflow, and a cleared prescaler only when it serves the counter.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int CNT_W  = 8;
  localparam int PRE_W  = 8;
  localparam int RATE_W = 3;
  localparam int MODE_W = 3 + RATE_W;

  typedef struct packed {
    logic              pin_src;
    logic              fall_edge;
    logic              to_wdt;
    logic [RATE_W-1:0] rate;
  } rtc_mode_t;

  // Mask of prescaler bits that must all be one for a tick to pass.
  function automatic logic [PRE_W-1:0] tap_mask(input logic [RATE_W-1:0] rate,
                                                input logic to_wdt);
    logic [PRE_W:0] one_hot;
    one_hot = (PRE_W+1)'(1) << rate;
    if (!to_wdt) one_hot = one_hot << 1;
    return PRE_W'(one_hot - (PRE_W+1)'(1));
  endfunction
endpackage

// File: rtl/rtc_pin_sync.sv
module rtc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[LAST];
  end

  assign rise = chain_q[LAST] & ~prev_q;
  assign fall = ~chain_q[LAST] & prev_q;
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_pkg::*;
#(
  parameter int W = PRE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_in,
  input  logic              clr,
  input  logic [RATE_W-1:0] rate,
  input  logic              to_wdt,
  output logic              tick
);
  logic [W-1:0] div_q;
  logic [W-1:0] mask;

  assign mask = W'(tap_mask(rate, to_wdt));
  assign tick = ev_in && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)     div_q <= '0;
    else if (clr)   div_q <= '0;
    else if (ev_in) div_q <= div_q + W'(1);
  end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] value,
  output logic         ovf
);
  logic wrap;

  assign wrap = inc && !wr_en && (value == {W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value <= '0;
      ovf   <= 1'b0;
    end else begin
      ovf <= wrap;
      if (wr_en)    value <= wr_data;
      else if (inc) value <= value + W'(1);
    end
  end
endmodule

// File: rtl/rtc_timer.sv
module rtc_timer
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_en,
  input  logic              ext_pin,
  input  logic              cnt_wr_en,
  input  logic [CNT_W-1:0]  cnt_wr_data,
  input  logic              mode_wr_en,
  input  logic [MODE_W-1:0] mode_wr_data,
  input  logic              wdt_tick_in,
  output logic [CNT_W-1:0]  cnt_value,
  output logic [MODE_W-1:0] mode_value,
  output logic              wdt_tick_out,
  output logic              ovf_pulse
);
  rtc_mode_t mode_q;
  logic      pin_rise, pin_fall, pin_ev, src_ev;
  logic      pre_in, pre_tick, cnt_inc, pre_clr;

  always_ff @(posedge clk) begin
    if (!rst_n)          mode_q <= '1;
    else if (mode_wr_en) mode_q <= rtc_mode_t'(mode_wr_data);
  end
  assign mode_value = mode_q;

  rtc_pin_sync #(.STAGES(2)) u_sync (
    .clk (clk), .rst_n (rst_n), .pin (ext_pin),
    .rise (pin_rise), .fall (pin_fall)
  );

  assign pin_ev = mode_q.fall_edge ? pin_fall : pin_rise;
  assign src_ev = mode_q.pin_src ? pin_ev : cyc_en;

  assign pre_in  = mode_q.to_wdt ? wdt_tick_in : src_ev;
  assign pre_clr = cnt_wr_en && !mode_q.to_wdt;

  rtc_prescaler #(.W(PRE_W)) u_pre (
    .clk (clk), .rst_n (rst_n), .ev_in (pre_in), .clr (pre_clr),
    .rate (mode_q.rate), .to_wdt (mode_q.to_wdt), .tick (pre_tick)
  );

  assign cnt_inc      = mode_q.to_wdt ? src_ev : pre_tick;
  assign wdt_tick_out = mode_q.to_wdt ? pre_tick : wdt_tick_in;

  rtc_counter #(.W(CNT_W)) u_cnt (
    .clk (clk), .rst_n (rst_n), .inc (cnt_inc),
    .wr_en (cnt_wr_en), .wr_data (cnt_wr_data),
    .value (cnt_value), .ovf (ovf_pulse)
  );
endmodule

// File: rtl/rtc_timer_chk.sv
module rtc_timer_chk
  import rtc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_en,
  input logic              ext_pin,
  input logic              cnt_wr_en,
  input logic [CNT_W-1:0]  cnt_wr_data,
  input logic              mode_wr_en,
  input logic [MODE_W-1:0] mode_wr_data,
  input logic              wdt_tick_in,
  input logic [CNT_W-1:0]  cnt_value,
  input logic [MODE_W-1:0] mode_value,
  input logic              wdt_tick_out,
  input logic              ovf_pulse
);
  a_r9_ovf_single: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse);

  a_r9_ovf_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> cnt_value == '0);

  a_r7_load_seen: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_en |=> cnt_value == $past(cnt_wr_data));

  a_r7_load_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_en |=> !ovf_pulse);

  a_r10_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr_en |=> mode_value == $past(mode_wr_data));

  a_r6_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr_en |=> (cnt_value == $past(cnt_value)) ||
                   (cnt_value == $past(cnt_value) + CNT_W'(1)));

  a_r5_no_tick_without_input: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_value[3] && !wdt_tick_in) |-> !wdt_tick_out);

  a_r2_cyc_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_value[3] && !mode_value[5] && !cyc_en && !cnt_wr_en) |=>
      cnt_value == $past(cnt_value));
endmodule

bind rtc_timer rtc_timer_chk u_chk (.*);

// File: tb/sim_rtc_timer.sv
`timescale 1ns/1ps
module sim_rtc_timer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cyc_en, ext_pin, cnt_wr_en, mode_wr_en, wdt_tick_in;
  logic [7:0] cnt_wr_data;
  logic [5:0] mode_wr_data;
  logic [7:0] cnt_value;
  logic [5:0] mode_value;
  logic       wdt_tick_out, ovf_pulse;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  rtc_timer u0 (.*);

  // reference model state
  logic       m_s1, m_s2, m_s3, m_ovf;
  logic [7:0] m_pre, m_cnt;
  logic [5:0] m_mode;
  logic       n_s1, n_s2, n_s3, n_ovf, e_wdt;
  logic [7:0] n_pre, n_cnt;
  logic [5:0] n_mode;
  int         wdt_seen;

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] div_mask(input logic [2:0] k, input logic wdt);
    int r;
    r = wdt ? (1 << k) : (2 << k);
    return 8'(r - 1);
  endfunction

  task automatic model_eval();
    logic edge_ev, ev, pin_in, ptick, inc, psa;
    logic [7:0] msk;
    psa     = m_mode[3];
    edge_ev = m_mode[4] ? (!m_s2 && m_s3) : (m_s2 && !m_s3);
    ev      = m_mode[5] ? edge_ev : cyc_en;
    pin_in  = psa ? wdt_tick_in : ev;
    msk     = div_mask(m_mode[2:0], psa);
    ptick   = pin_in && ((m_pre & msk) == msk);
    e_wdt   = psa ? ptick : wdt_tick_in;
    inc     = psa ? ev : ptick;
    n_pre   = (cnt_wr_en && !psa) ? 8'd0 : (pin_in ? m_pre + 8'd1 : m_pre);
    n_cnt   = cnt_wr_en ? cnt_wr_data : (inc ? m_cnt + 8'd1 : m_cnt);
    n_ovf   = !cnt_wr_en && inc && (m_cnt == 8'hFF);
    n_mode  = mode_wr_en ? mode_wr_data : m_mode;
    n_s1 = ext_pin; n_s2 = m_s1; n_s3 = m_s2;
  endtask

  task automatic step(input string tag);
    #1;
    model_eval();
    check({7'd0, wdt_tick_out}, {7'd0, e_wdt}, tag);
    if (wdt_tick_out) wdt_seen++;
    @(posedge clk);
    @(negedge clk);
    m_s1 = n_s1; m_s2 = n_s2; m_s3 = n_s3;
    m_pre = n_pre; m_cnt = n_cnt; m_ovf = n_ovf; m_mode = n_mode;
    check(cnt_value, m_cnt, tag);
    check({7'd0, ovf_pulse}, {7'd0, m_ovf}, tag);
    check({2'd0, mode_value}, {2'd0, m_mode}, tag);
    cnt_wr_en = 0; mode_wr_en = 0; cyc_en = 0; wdt_tick_in = 0;
  endtask

  task automatic set_mode(input logic [5:0] m);
    mode_wr_en = 1; mode_wr_data = m;
    step("R10");
  endtask

  task automatic load_cnt(input logic [7:0] v, input string tag);
    cnt_wr_en = 1; cnt_wr_data = v;
    step(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; cyc_en = 0; ext_pin = 0; cnt_wr_en = 0; mode_wr_en = 0;
    wdt_tick_in = 0; cnt_wr_data = 0; mode_wr_data = 0;
    m_s1 = 0; m_s2 = 0; m_s3 = 0; m_pre = 0; m_cnt = 0; m_ovf = 0; m_mode = 6'h3F;
    wdt_seen = 0;
    repeat (3) @(negedge clk);
    check({2'd0, mode_value}, 8'h3F, "R1");
    check(cnt_value, 8'h00, "R1");
    rst_n = 1;
    step("R1");
    check({2'd0, mode_value}, 8'h3F, "R1");
    check({7'd0, ovf_pulse}, 8'h00, "R1");

    // R4/R9: internal source, ratio 1:2, wrap
    set_mode(6'b000000);
    load_cnt(8'hFE, "R7");
    for (int i = 0; i < 4; i++) begin cyc_en = 1; step("R4"); end
    check(cnt_value, 8'h00, "R9");
    check({7'd0, ovf_pulse}, 8'h01, "R9");
    step("R9");
    check({7'd0, ovf_pulse}, 8'h00, "R9");

    // R8: ratio 1:8, write mid-period clears prescaler
    set_mode(6'b000010);
    for (int i = 0; i < 5; i++) begin cyc_en = 1; step("R8"); end
    load_cnt(8'h10, "R8");
    for (int i = 0; i < 7; i++) begin cyc_en = 1; step("R8"); end
    check(cnt_value, 8'h10, "R8");
    cyc_en = 1; step("R8");
    check(cnt_value, 8'h11, "R8");

    // R6/R7: no prescale, write during increment wins
    set_mode(6'b001000);
    cyc_en = 1; step("R6");
    check(cnt_value, 8'h12, "R6");
    cyc_en = 1; cnt_wr_en = 1; cnt_wr_data = 8'hFF; step("R7");
    check(cnt_value, 8'hFF, "R7");
    check({7'd0, ovf_pulse}, 8'h00, "R7");

    // R5: watchdog 1:8
    set_mode(6'b001011);
    wdt_seen = 0;
    for (int i = 0; i < 16; i++) begin wdt_tick_in = 1; step("R5"); end
    check(8'(wdt_seen), 8'd2, "R5");

    // R3: pin source, falling edge, latency
    set_mode(6'b111000);
    load_cnt(8'h40, "R3");
    ext_pin = 1; step("R3"); step("R3"); step("R3"); step("R3");
    check(cnt_value, 8'h40, "R3");
    ext_pin = 0; step("R3");
    step("R3");
    check(cnt_value, 8'h40, "R3");
    step("R3");
    check(cnt_value, 8'h41, "R3");
    // R2: cyc_en ignored with pin source
    for (int i = 0; i < 4; i++) begin cyc_en = 1; step("R2"); end
    check(cnt_value, 8'h41, "R2");

    // random phase
    for (int i = 0; i < 6000; i++) begin
      cyc_en      = $urandom_range(0, 1);
      wdt_tick_in = $urandom_range(0, 1);
      if ($urandom_range(0, 3) == 0) ext_pin = ~ext_pin;
      if ($urandom_range(0, 40) == 0) begin
        mode_wr_en = 1; mode_wr_data = 6'($urandom);
        if ($urandom_range(0, 1) == 1) mode_wr_data[2:0] = 3'($urandom_range(0, 2));
      end
      if ($urandom_range(0, 60) == 0) begin
        cnt_wr_en = 1; cnt_wr_data = ($urandom_range(0, 1) == 1) ? 8'hFF : 8'($urandom);
      end
      step("R7");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule